// File: doc/BRIEF.md
# DMA-Linked Interrupt Flag Sequencer

This block sits between one peripheral interrupt source and a channel of a table-driven DMA engine. A factor event sets a flag. If the DMA request bit and the DMA enable bit are both set, the flag starts one DMA transfer through a start/done handshake and the CPU is not interrupted. If either bit is clear, the flag goes through the normal interrupt path, gated by the source's interrupt enable and the CPU global enable.

Each transfer that completes lowers a per-channel transfer count by one. Before the count runs out, a completed transfer clears the flag and raises no interrupt. At terminal count, the end-interrupt option decides the outcome. With the option set, the flag is kept, the request bit drops and the CPU is interrupted. With the option clear, the flag and the enable bit drop, the request bit is left set, and later events stop reaching the DMA. Software programs the bits through a select/data write port.

Top module: `dmairq_seq`

## Requirements
- R1: Asynchronous reset (rst_ni low) clears the flag, request, enable, end-interrupt enable, interrupt enable, global enable, count and busy state. After reset, dma_start_o and irq_o are 0.
- R2: In the idle state, when flag, request and enable are all 1, dma_start_o pulses high for exactly one cycle, on the cycle after the flag becomes visible. The block is then busy until dma_done_i is sampled high.
- R3: Each done sampled while busy lowers cnt_o by exactly one on that edge. A count of 0 stays at 0.
- R4: At a done edge with cnt_o above 1, the flag is cleared, request and enable are unchanged, and no interrupt is raised.
- R5: At a done edge with cnt_o at 1 or 0 and end-interrupt enable 1, the flag stays 1, the request bit clears to 0, and the enable bit is kept. irq_o rises one cycle later if the interrupt enable and the global enable are both 1.
- R6: At a done edge with cnt_o at 1 or 0 and end-interrupt enable 0, the flag clears, the request bit stays 1, the enable bit clears to 0, and no interrupt is raised.
- R7: Once the enable bit is 0, factor events still set the flag but start no transfer. The flag then follows the interrupt path.
- R8: irq_o is registered. It is 1 one cycle after flag=1 with interrupt enable=1, global enable=1, not busy, and not (request and enable). If either enable is 0, irq_o is 0.
- R9: A factor event that arrives while busy is held. The flag is set again at the done edge and a second transfer follows.
- R10: Write selects (wr_sel_i): 0 clears the flag when wr_data_i[0]=1, 1 writes the request bit, 2 writes the enable bit, 3 loads the count from wr_data_i, 4 writes end-interrupt enable, 5 writes interrupt enable, 6 writes global enable (bits take wr_data_i[0]). A flag-clear write in the same cycle as factor_i leaves the flag set.
- R11: dma_done_i while not busy has no effect; cnt_o and the flag are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| factor_i | input | 1 | Interrupt factor event, one cycle per event |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | CNT_W | Write data |
| dma_start_o | output | 1 | One-cycle transfer start to DMA engine |
| dma_done_i | input | 1 | Transfer complete from DMA engine |
| irq_o | output | 1 | Registered CPU interrupt request |
| flag_o | output | 1 | Factor flag state |
| dreq_o | output | 1 | DMA request bit |
| den_o | output | 1 | DMA enable bit |
| cnt_o | output | CNT_W | Transfer count |

## Verification
A wrong terminal-count decision is visible at the done edge. In the kept-flag case, dreq_o drops or stays high. In the dropped case, den_o stays high and a start appears on the next event. irq_o follows one cycle later. A stuck busy state or a lost pending event shows within a few cycles as a missing or extra dma_start_o pulse, and as a cnt_o that fails to fall. Since the reference model is compared on every clock, any divergence is reported on the cycle it first reaches a port.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  typedef enum logic [2:0] {
    SEL_FLAG_CLR = 3'd0,
    SEL_DREQ     = 3'd1,
    SEL_DEN      = 3'd2,
    SEL_CNT      = 3'd3,
    SEL_ENDIE    = 3'd4,
    SEL_IE       = 3'd5,
    SEL_GIE      = 3'd6
  } reg_sel_e;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_BUSY = 1'b1
  } xfer_st_e;
endpackage

// File: rtl/dmairq_flag.sv
module dmairq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic busy_i,
  input  logic fin_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pend_o
);
  logic set;

  // event held during a transfer re-arms the flag at completion
  assign set = ev_i | (fin_i & pend_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      if (set)        flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
      if (fin_i)               pend_o <= 1'b0;
      else if (busy_i && ev_i) pend_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dmairq_xfer.sv
module dmairq_xfer
  import dmairq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic done_i,
  output logic busy_o,
  output logic fin_o,
  output logic start_o
);
  xfer_st_e st_q;

  assign busy_o = (st_q == XS_BUSY);
  assign fin_o  = busy_o & done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= XS_IDLE;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      case (st_q)
        XS_IDLE: if (go_i) begin
          st_q    <= XS_BUSY;
          start_o <= 1'b1;
        end
        default: if (done_i) st_q <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmairq_tc.sv
module dmairq_tc #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign last_o = (cnt_o <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (load_i)                 cnt_o <= load_val_i;
    else if (dec_i && cnt_o != '0)   cnt_o <= cnt_o - ONE;
  end
endmodule

// File: rtl/dmairq_gate.sv
module dmairq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  input  logic ie_i,
  input  logic gie_i,
  input  logic dma_route_i,
  input  logic busy_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= flag_i & ie_i & gie_i & ~dma_route_i & ~busy_i;
  end
endmodule

// File: rtl/dmairq_seq.sv
module dmairq_seq
  import dmairq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             factor_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             dma_start_o,
  input  logic             dma_done_i,
  output logic             irq_o,
  output logic             flag_o,
  output logic             dreq_o,
  output logic             den_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic busy, fin, pend, last;
  logic endie_q, ie_q, gie_q;
  logic term_keep, term_drop, flag_clr, go;
  logic wr_flag, wr_dreq, wr_den, wr_cnt, wr_endie, wr_ie, wr_gie;

  assign wr_flag  = wr_en_i && (wr_sel_i == SEL_FLAG_CLR) && wr_data_i[0];
  assign wr_dreq  = wr_en_i && (wr_sel_i == SEL_DREQ);
  assign wr_den   = wr_en_i && (wr_sel_i == SEL_DEN);
  assign wr_cnt   = wr_en_i && (wr_sel_i == SEL_CNT);
  assign wr_endie = wr_en_i && (wr_sel_i == SEL_ENDIE);
  assign wr_ie    = wr_en_i && (wr_sel_i == SEL_IE);
  assign wr_gie   = wr_en_i && (wr_sel_i == SEL_GIE);

  assign term_keep = fin & last & endie_q;
  assign term_drop = fin & last & ~endie_q;
  assign flag_clr  = wr_flag | (fin & ~term_keep);
  assign go        = flag_o & dreq_o & den_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dreq_o  <= 1'b0;
      den_o   <= 1'b0;
      endie_q <= 1'b0;
      ie_q    <= 1'b0;
      gie_q   <= 1'b0;
    end else begin
      if (wr_dreq)        dreq_o <= wr_data_i[0];
      else if (term_keep) dreq_o <= 1'b0;
      if (wr_den)         den_o  <= wr_data_i[0];
      else if (term_drop) den_o  <= 1'b0;
      if (wr_endie) endie_q <= wr_data_i[0];
      if (wr_ie)    ie_q    <= wr_data_i[0];
      if (wr_gie)   gie_q   <= wr_data_i[0];
    end
  end

  dmairq_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (factor_i),
    .busy_i (busy),
    .fin_i  (fin),
    .clr_i  (flag_clr),
    .flag_o (flag_o),
    .pend_o (pend)
  );

  dmairq_xfer u_xfer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .done_i  (dma_done_i),
    .busy_o  (busy),
    .fin_o   (fin),
    .start_o (dma_start_o)
  );

  dmairq_tc #(.CNT_W(CNT_W)) u_tc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_cnt),
    .load_val_i (wr_data_i),
    .dec_i      (fin),
    .cnt_o      (cnt_o),
    .last_o     (last)
  );

  dmairq_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flag_i      (flag_o),
    .ie_i        (ie_q),
    .gie_i       (gie_q),
    .dma_route_i (dreq_o & den_o),
    .busy_i      (busy),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/dmairq_seq_chk.sv
module dmairq_seq_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             factor_i,
  input logic             wr_en_i,
  input logic             dma_start_o,
  input logic             irq_o,
  input logic             flag_o,
  input logic             dreq_o,
  input logic             den_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             busy,
  input logic             fin,
  input logic             pend,
  input logic             endie_q,
  input logic             ie_q,
  input logic             gie_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_start_o |=> !dma_start_o);
  // R2
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_start_o) |-> $past(flag_o && dreq_o && den_o));
  // R3
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !wr_en_i && cnt_o != '0) |=> (cnt_o == CNT_W'($past(cnt_o) - ONE)));
  // R4
  mid_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && cnt_o > ONE && !factor_i && !pend && !wr_en_i) |=> !flag_o);
  // R5
  end_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && cnt_o <= ONE && endie_q && !wr_en_i) |=> (flag_o && !dreq_o));
  // R6
  end_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && cnt_o <= ONE && !endie_q && dreq_o && !factor_i && !pend && !wr_en_i)
      |=> (!flag_o && dreq_o && !den_o));
  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(flag_o && ie_q && gie_q));
  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    factor_i |=> flag_o);
  // R11
  idle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !wr_en_i) |=> $stable(cnt_o));
endmodule

bind dmairq_seq dmairq_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .factor_i    (factor_i),
  .wr_en_i     (wr_en_i),
  .dma_start_o (dma_start_o),
  .irq_o       (irq_o),
  .flag_o      (flag_o),
  .dreq_o      (dreq_o),
  .den_o       (den_o),
  .cnt_o       (cnt_o),
  .busy        (busy),
  .fin         (fin),
  .pend        (pend),
  .endie_q     (endie_q),
  .ie_q        (ie_q),
  .gie_q       (gie_q)
);

// File: tb/dmairq_seq_tb_top.sv
`timescale 1ns/1ps
module dmairq_seq_tb_top;
  localparam int CNT_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic factor_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic eng_done = 1'b0;
  logic stray_done = 1'b0;
  logic dma_done_i;
  logic dma_start_o, irq_o, flag_o, dreq_o, den_o;
  logic [CNT_W-1:0] cnt_o;

  int errors = 0;
  int checks = 0;
  int n_start = 0;
  int eng_cnt = 0;
  int lat = 3;
  int wd = 0;
  bit finished = 0;

  // reference model state
  bit m_flag, m_pend, m_busy, m_start, m_irq, m_dreq, m_den, m_endie, m_ie, m_gie;
  int m_cnt;

  assign dma_done_i = eng_done | stray_done;

  always #2 clk_i = ~clk_i;

  dmairq_seq #(.CNT_W(CNT_W)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .factor_i    (factor_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .dma_start_o (dma_start_o),
    .dma_done_i  (dma_done_i),
    .irq_o       (irq_o),
    .flag_o      (flag_o),
    .dreq_o      (dreq_o),
    .den_o       (den_o),
    .cnt_o       (cnt_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flag = 0; m_pend = 0; m_busy = 0; m_start = 0; m_irq = 0;
      m_dreq = 0; m_den = 0; m_endie = 0; m_ie = 0; m_gie = 0; m_cnt = 0;
    end else begin
      bit fin, keep, drop, go, irqn, set, clr;
      fin  = m_busy && dma_done_i;
      keep = fin && (m_cnt <= 1) && m_endie;
      drop = fin && (m_cnt <= 1) && !m_endie;
      go   = !m_busy && m_flag && m_dreq && m_den;
      irqn = m_flag && m_ie && m_gie && !(m_dreq && m_den) && !m_busy;
      set  = factor_i || (fin && m_pend);
      clr  = (wr_en_i && wr_sel_i == 3'd0 && wr_data_i[0]) || (fin && !keep);
      if (fin) m_pend = 0; else if (m_busy && factor_i) m_pend = 1;
      m_start = go;
      if (go) m_busy = 1; else if (fin) m_busy = 0;
      m_irq = irqn;
      if (wr_en_i && wr_sel_i == 3'd3) m_cnt = int'(wr_data_i);
      else if (fin && m_cnt > 0) m_cnt = m_cnt - 1;
      if (wr_en_i && wr_sel_i == 3'd1) m_dreq = wr_data_i[0]; else if (keep) m_dreq = 0;
      if (wr_en_i && wr_sel_i == 3'd2) m_den = wr_data_i[0]; else if (drop) m_den = 0;
      if (wr_en_i && wr_sel_i == 3'd4) m_endie = wr_data_i[0];
      if (wr_en_i && wr_sel_i == 3'd5) m_ie = wr_data_i[0];
      if (wr_en_i && wr_sel_i == 3'd6) m_gie = wr_data_i[0];
      if (set) m_flag = 1; else if (clr) m_flag = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk("R2 dma_start_o", int'(dma_start_o), int'(m_start));
      chk("R4 flag_o", int'(flag_o), int'(m_flag));
      chk("R5 dreq_o", int'(dreq_o), int'(m_dreq));
      chk("R6 den_o", int'(den_o), int'(m_den));
      chk("R3 cnt_o", int'(cnt_o), m_cnt);
      chk("R8 irq_o", int'(irq_o), int'(m_irq));
    end
  end

  // DMA engine responder
  always @(negedge clk_i) begin
    eng_done = 1'b0;
    if (!rst_ni) eng_cnt = 0;
    else if (dma_start_o) begin
      n_start++;
      eng_cnt = lat;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) eng_done = 1'b1;
    end
  end

  always @(posedge clk_i) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", wd);
      summary();
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] sel, input int data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = CNT_W'(data);
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic pulse();
    factor_i = 1'b1;
    tick();
    factor_i = 1'b0;
  endtask

  initial begin
    int s0;
    tick(3);
    // R1: outputs during and after reset
    chk("R1 irq_o", int'(irq_o), 0);
    chk("R1 dma_start_o", int'(dma_start_o), 0);
    chk("R1 cnt_o", int'(cnt_o), 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 flag/dreq/den", int'({flag_o, dreq_o, den_o}), 0);

    // R8: normal interrupt path
    wr(3'd5, 1); wr(3'd6, 1);
    pulse(); tick(2);
    chk("R8 irq with enables", int'(irq_o), 1);
    wr(3'd0, 1); tick(2);
    chk("R8 irq after clear", int'(irq_o), 0);
    wr(3'd6, 0);
    pulse(); tick(2);
    chk("R8 irq global off", int'(irq_o), 0);
    wr(3'd0, 1); wr(3'd6, 1);

    // R2 R3 R4 R5: three transfers, end interrupt enabled
    wr(3'd3, 3); wr(3'd4, 1); wr(3'd1, 1); wr(3'd2, 1);
    s0 = n_start;
    pulse(); tick(12);
    chk("R2 one start", n_start - s0, 1);
    chk("R3 cnt after one", int'(cnt_o), 2);
    chk("R4 flag cleared", int'(flag_o), 0);
    chk("R4 no irq", int'(irq_o), 0);
    pulse(); tick(12);
    chk("R3 cnt after two", int'(cnt_o), 1);
    pulse(); tick(12);
    chk("R3 cnt at zero", int'(cnt_o), 0);
    chk("R5 flag kept", int'(flag_o), 1);
    chk("R5 dreq cleared", int'(dreq_o), 0);
    chk("R5 den kept", int'(den_o), 1);
    chk("R5 irq raised", int'(irq_o), 1);
    wr(3'd0, 1); tick(2);

    // R6 R7: end interrupt disabled
    wr(3'd3, 2); wr(3'd4, 0); wr(3'd1, 1);
    pulse(); tick(12); pulse(); tick(12);
    chk("R6 flag cleared", int'(flag_o), 0);
    chk("R6 dreq stays", int'(dreq_o), 1);
    chk("R6 den cleared", int'(den_o), 0);
    chk("R6 no irq", int'(irq_o), 0);
    s0 = n_start;
    pulse(); tick(12);
    chk("R7 no start", n_start - s0, 0);
    chk("R7 flag set", int'(flag_o), 1);
    chk("R7 irq path", int'(irq_o), 1);
    wr(3'd0, 1); tick(2);

    // R9: event during transfer is held
    wr(3'd3, 5); wr(3'd2, 1);
    s0 = n_start;
    pulse(); tick(3); pulse(); tick(25);
    chk("R9 two starts", n_start - s0, 2);
    chk("R9 cnt", int'(cnt_o), 3);
    chk("R9 flag idle", int'(flag_o), 0);

    // R10: set wins over software clear
    wr(3'd1, 0); wr(3'd5, 0);
    pulse();
    factor_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = CNT_W'(1);
    tick();
    factor_i = 1'b0; wr_en_i = 1'b0;
    tick();
    chk("R10 set wins", int'(flag_o), 1);
    wr(3'd0, 1); tick();
    chk("R10 clear", int'(flag_o), 0);

    // R11: stray done while idle
    stray_done = 1'b1; tick(); stray_done = 1'b0; tick(2);
    chk("R11 cnt unchanged", int'(cnt_o), 3);
    chk("R11 flag unchanged", int'(flag_o), 0);

    summary();
  end
endmodule